// File: doc/BRIEF.md
# Packed Tag Storage Writer

This block places 4-bit allocation tags into a byte-wide tag RAM that packs the tags of two 16-byte granules into each byte. The granule at the lower address sits in the low nibble and the granule at the higher address sits in the high nibble. The block accepts one store command at a time. A command carries a byte address, a tag and an operation code. The block then drives a simple synchronous RAM port until the command is finished.

There are three store kinds:

- **Single granule.** Updates one nibble by reading the byte, merging the new nibble and writing the byte back.
- **Double granule.** Covers two consecutive granules. If the address is aligned to 32 bytes, it writes one whole byte without reading. If the address is an odd granule, it does two read-modify-writes on neighbouring bytes.
- **Block fill.** Rounds the address down to the block size and writes the replicated tag into every tag byte of that block.

A misaligned single or double store raises a one-cycle fault and writes nothing. When the page is marked as not holding tags, the command is swallowed without touching the RAM.

Commands use a valid/ready handshake. A command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low while a RAM sequence is in progress, and the requester must hold its command until it is taken. The RAM returns read data on the cycle after `mem_rd`.

Top module: `tag_store_writer`

## Requirements
- R1: The tag byte index is the address shifted right by 5 (granule size 16, two granules per byte). Address bit 4 selects the nibble: 0 selects bits [3:0] and 1 selects bits [7:4].
- R2: A single store (op 0) reads the target byte, then on the next cycle writes it back to the same index. Only the selected nibble is replaced; the other nibble keeps its value.
- R3: A single or double store whose address bits [3:0] are not zero raises `fault` for exactly the cycle after acceptance and issues no RAM read or write.
- R4: A double store (op 1) with address bit 4 clear writes one byte equal to the tag replicated in both nibbles, with no read.
- R5: A double store with address bit 4 set replaces the high nibble of byte N, then the low nibble of byte N+1, each by read-modify-write. The other nibble of each byte is preserved.
- R6: A block fill (op 2) clears the low log2(block) address bits and writes tag*0x11 into every tag byte of the block. It never faults, whatever the low address bits are.
- R7: With `page_tagged` low, an aligned command is accepted and makes no RAM access and raises no fault.
- R8: `cmd_ready` is low (and `busy` high) from the cycle after a command that needs the RAM until its last write. A command offered in that time is not taken.
- R9: Op code 3 is accepted and has no effect on the RAM or on `fault`.
- R10: After reset, `cmd_ready` is high and `mem_rd`, `mem_we` and `fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 2 | 0 single, 1 double, 2 block fill, 3 no-op |
| cmd_addr | input | ADDR_W | Byte address of the data being tagged |
| cmd_tag | input | 4 | Tag value to store |
| page_tagged | input | 1 | Page holds tags; low drops the store |
| mem_rd | output | 1 | RAM read strobe |
| mem_we | output | 1 | RAM write strobe |
| mem_addr | output | ADDR_W-5 | RAM byte index |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, valid the cycle after `mem_rd` |
| fault | output | 1 | Alignment fault pulse |
| busy | output | 1 | RAM sequence in progress |

## Verification
Assertions check several rules on every cycle:
- every read is followed by a write to the same index;
- reads and writes never coincide;
- a fault comes only right after an accepted command and is never accompanied by RAM traffic;
- fill bytes always carry equal nibbles;
- no RAM traffic occurs while the block reports ready.

Only the bench scenarios can show the actual data: that the right nibble lands in the right byte, that neighbour nibbles survive, that the block base is rounded down, and that dropped and no-op commands leave the memory unchanged. The bench shows this by comparing the whole RAM against a shadow copy after every command.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  typedef enum logic [1:0] {
    OP_ONE = 2'd0,
    OP_TWO = 2'd1,
    OP_BLK = 2'd2,
    OP_NOP = 2'd3
  } tag_op_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RD   = 2'd1,
    S_WR   = 2'd2,
    S_FILL = 2'd3
  } wr_state_e;
endpackage

// File: rtl/tsw_decode.sv
module tsw_decode #(
  parameter int ADDR_W    = 16,
  parameter int GRAN_LOG2 = 4,
  parameter int BLK_LOG2  = 6,
  localparam int TA_W     = ADDR_W - GRAN_LOG2 - 1,
  localparam int FILL_N   = 1 << (BLK_LOG2 - GRAN_LOG2 - 1)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              misaligned,
  output logic              hi_nib,
  output logic [TA_W-1:0]   byte_idx,
  output logic [TA_W-1:0]   blk_idx
);
  assign misaligned = |addr[GRAN_LOG2-1:0];
  assign hi_nib     = addr[GRAN_LOG2];
  assign byte_idx   = addr[ADDR_W-1:GRAN_LOG2+1];
  assign blk_idx    = byte_idx & ~TA_W'(FILL_N - 1);
endmodule

// File: rtl/tsw_merge.sv
module tsw_merge (
  input  logic [7:0] old_byte,
  input  logic [3:0] tag,
  input  logic       hi,
  output logic [7:0] new_byte
);
  always_comb begin
    new_byte = old_byte;
    if (hi) new_byte[7:4] = tag;
    else    new_byte[3:0] = tag;
  end
endmodule

// File: rtl/tag_store_writer.sv
module tag_store_writer
  import tsw_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int GRAN_LOG2 = 4,
  parameter int BLK_LOG2  = 6,
  localparam int TA_W     = ADDR_W - GRAN_LOG2 - 1,
  localparam int FILL_N   = 1 << (BLK_LOG2 - GRAN_LOG2 - 1),
  localparam int CNT_W    = $clog2(FILL_N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [3:0]        cmd_tag,
  input  logic              page_tagged,
  output logic              mem_rd,
  output logic              mem_we,
  output logic [TA_W-1:0]   mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              fault,
  output logic              busy
);
  wr_state_e        state_q;
  logic [TA_W-1:0]  ptr_q;
  logic [3:0]       tag_q;
  logic             hi_q, split_q;
  logic [CNT_W-1:0] cnt_q;
  logic             fault_q;

  logic            mis, hin;
  logic [TA_W-1:0] bidx, kidx;
  logic [7:0]      merged;
  logic            accept;
  tag_op_e         op;

  tsw_decode #(.ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2), .BLK_LOG2(BLK_LOG2)) u_dec (
    .addr(cmd_addr), .misaligned(mis), .hi_nib(hin), .byte_idx(bidx), .blk_idx(kidx)
  );

  tsw_merge u_mrg (.old_byte(mem_rdata), .tag(tag_q), .hi(hi_q), .new_byte(merged));

  assign op        = tag_op_e'(cmd_op);
  assign cmd_ready = (state_q == S_IDLE);
  assign busy      = !cmd_ready;
  assign accept    = cmd_valid && cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ptr_q   <= '0;
      tag_q   <= '0;
      hi_q    <= 1'b0;
      split_q <= 1'b0;
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      fault_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (accept) begin
          tag_q <= cmd_tag;
          unique case (op)
            OP_ONE: begin
              if (mis) fault_q <= 1'b1;
              else if (page_tagged) begin
                ptr_q <= bidx; hi_q <= hin; split_q <= 1'b0; state_q <= S_RD;
              end
            end
            OP_TWO: begin
              if (mis) fault_q <= 1'b1;
              else if (page_tagged) begin
                ptr_q <= bidx;
                if (hin) begin
                  hi_q <= 1'b1; split_q <= 1'b1; state_q <= S_RD;
                end else begin
                  cnt_q <= CNT_W'(1); state_q <= S_FILL;
                end
              end
            end
            OP_BLK: if (page_tagged) begin
              ptr_q <= kidx; cnt_q <= CNT_W'(FILL_N); state_q <= S_FILL;
            end
            default: ;
          endcase
        end
        S_RD: state_q <= S_WR;
        S_WR: begin
          if (split_q) begin
            ptr_q   <= ptr_q + 1'b1;
            hi_q    <= 1'b0;
            split_q <= 1'b0;
            state_q <= S_RD;
          end else state_q <= S_IDLE;
        end
        S_FILL: begin
          ptr_q <= ptr_q + 1'b1;
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign mem_rd    = (state_q == S_RD);
  assign mem_we    = (state_q == S_WR) || (state_q == S_FILL);
  assign mem_addr  = ptr_q;
  assign mem_wdata = (state_q == S_FILL) ? {tag_q, tag_q} : merged;
  assign fault     = fault_q;

  assert_rmw_same_idx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> mem_we && $stable(mem_addr));
  assert_rd_we_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_we));
  assert_fault_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $past(cmd_valid && cmd_ready));
  assert_fault_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !mem_rd && !mem_we);
  assert_fill_replicated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !$past(mem_rd)) |-> mem_wdata[7:4] == mem_wdata[3:0]);
  assert_no_ram_when_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mem_rd && !mem_we);
endmodule

// File: tb/tb_tag_store_writer.sv
module tb_tag_store_writer;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int TA_W   = 11;
  localparam int NBYTES = 1 << TA_W;
  localparam int NVEC   = 12;

  // fields: op[22:21] addr[20:5] tag[4:1] page_tagged[0]
  localparam logic [22:0] VEC [NVEC] = '{
    {2'd0, 16'h0000, 4'h5, 1'b1},   // R1 R2 low nibble
    {2'd0, 16'h0010, 4'hA, 1'b1},   // R1 R2 high nibble
    {2'd0, 16'h0008, 4'h3, 1'b1},   // R3 misaligned single
    {2'd1, 16'h0040, 4'h3, 1'b1},   // R4 whole byte
    {2'd0, 16'h0070, 4'h9, 1'b1},   // preload high nibble of byte 3
    {2'd1, 16'h0050, 4'hC, 1'b1},   // R5 split
    {2'd1, 16'h0044, 4'h1, 1'b1},   // R3 misaligned double
    {2'd2, 16'h0127, 4'hE, 1'b1},   // R6 rounds down, no fault
    {2'd0, 16'h0200, 4'h6, 1'b0},   // R7 dropped
    {2'd2, 16'h0300, 4'h4, 1'b0},   // R7 dropped fill
    {2'd3, 16'h0400, 4'h1, 1'b1},   // R9 no-op
    {2'd0, 16'h0130, 4'h2, 1'b1}    // R2 after fill
  };

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, page_tagged = 1;
  logic [1:0] cmd_op = 0;
  logic [ADDR_W-1:0] cmd_addr = 0;
  logic [3:0] cmd_tag = 0;
  logic cmd_ready, mem_rd, mem_we, fault, busy;
  logic [TA_W-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  logic [7:0] ram [NBYTES];
  logic [7:0] shadow [NBYTES];
  int total = 0, bad = 0, rd_n = 0, we_n = 0, cyc = 0;
  logic done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tag_store_writer dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_tag(cmd_tag), .page_tagged(page_tagged),
    .mem_rd(mem_rd), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .fault(fault), .busy(busy)
  );

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= ram[mem_addr];
    if (mem_rd) rd_n <= rd_n + 1;
    if (mem_we) we_n <= we_n + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      finish_run();
    end
  end

  function automatic void model(input logic [1:0] op, input logic [15:0] a,
                                input logic [3:0] t, input logic ok);
    int idx;
    idx = int'(a >> 5);
    if (op == 2'd0 && a[3:0] == 0 && ok) begin
      if (a[4]) shadow[idx][7:4] = t; else shadow[idx][3:0] = t;
    end else if (op == 2'd1 && a[3:0] == 0 && ok) begin
      if (!a[4]) shadow[idx] = {t, t};
      else begin shadow[idx][7:4] = t; shadow[idx+1][3:0] = t; end
    end else if (op == 2'd2 && ok) begin
      idx = int'((a & 16'hFFC0) >> 5);
      shadow[idx] = {t, t}; shadow[idx+1] = {t, t};
    end
  endfunction

  task automatic run_cmd(input logic [1:0] op, input logic [15:0] a,
                         input logic [3:0] t, input logic ok, input string req);
    int mism, exp_rd, exp_we, first;
    bit exp_f;
    exp_f = (op < 2) && (a[3:0] != 0);
    exp_rd = 0; exp_we = 0;
    if (!exp_f && ok) begin
      if (op == 0) begin exp_rd = 1; exp_we = 1; end
      if (op == 1) begin exp_rd = a[4] ? 2 : 0; exp_we = a[4] ? 2 : 1; end
      if (op == 2) begin exp_we = 2; end
    end
    @(negedge clk);
    rd_n = 0; we_n = 0;
    cmd_op = op; cmd_addr = a; cmd_tag = t; page_tagged = ok; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    check(fault == exp_f, {req, " fault"}, fault, exp_f);
    for (int i = 0; i < 20 && !cmd_ready; i++) @(negedge clk);
    @(negedge clk);
    model(op, a, t, ok);
    mism = 0; first = -1;
    for (int i = 0; i < NBYTES; i++)
      if (ram[i] !== shadow[i]) begin mism++; if (first < 0) first = i; end
    check(mism == 0, {req, " ram"}, first < 0 ? 0 : ram[first], first < 0 ? 0 : shadow[first]);
    check(rd_n == exp_rd && we_n == exp_we, {req, " traffic"}, rd_n * 16 + we_n,
          exp_rd * 16 + exp_we);
  endtask

  initial begin
    for (int i = 0; i < NBYTES; i++) begin ram[i] = 8'h00; shadow[i] = 8'h00; end
    repeat (3) @(negedge clk);
    // R10 reset state
    check(cmd_ready && !mem_rd && !mem_we && !fault && !busy, "R10",
          {cmd_ready, mem_rd, mem_we, fault}, 4'b1000);
    rst_n = 1;
    for (int v = 0; v < NVEC; v++)
      run_cmd(VEC[v][22:21], VEC[v][20:5], VEC[v][4:1], VEC[v][0], $sformatf("vec%0d", v));

    // R8: a second command offered while a fill is busy must not be taken
    @(negedge clk);
    rd_n = 0; we_n = 0;
    cmd_op = 2'd2; cmd_addr = 16'h0500; cmd_tag = 4'h7; page_tagged = 1; cmd_valid = 1;
    @(negedge clk);
    cmd_op = 2'd0; cmd_addr = 16'h0600; cmd_tag = 4'hB;
    check(!cmd_ready && busy, "R8 busy", cmd_ready, 0);
    @(negedge clk);
    cmd_valid = 0;
    for (int i = 0; i < 20 && !cmd_ready; i++) @(negedge clk);
    @(negedge clk);
    model(2'd2, 16'h0500, 4'h7, 1'b1);
    check(ram[48] == shadow[48] && ram[40] == 8'h77 && ram[41] == 8'h77,
          "R8 offered cmd ignored", ram[48], shadow[48]);

    // R6 block fill with high tag on top of earlier data, block base 0x0000
    run_cmd(2'd2, 16'h003F, 4'hF, 1'b1, "R6 fill rounds down");
    // R5 split across a block boundary byte pair
    run_cmd(2'd1, 16'h0030, 4'h8, 1'b1, "R5 split keeps neighbours");
    done = 1;
    finish_run();
  end
endmodule